// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path

This block sits between the read port of a synchronous SRAM array and the shared data bus. For every rising clock edge it accepts one command: start a read, deselect, or neither (a burst beat that carries on with what the last command set up). It decides when the bus is driven and which data it carries. A mode input picks between two output stages. In pipelined mode an output register sits between the array and the bus. In flow-through mode the array data passes straight to the bus and that clock stage is skipped.

Deselect commands travel through exactly as many register stages as reads do. The bus therefore keeps its driver on for as long after a deselect as a read would have needed to reach it, and only then releases. Two inputs gate the driver combinationally, without waiting for a clock edge: an output enable and a sleep request. The drive state held in the pipeline survives both, so the bus comes back as soon as the gate reopens. Data is forced to zero whenever the driver is off, so the bus value is never unknown.

Top module: `sram_read_path`

## Requirements
- R1: While reset is applied and after any clock edge where it was sampled low, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: With `pipe_mode` = 1, a read sampled at edge k makes `dq_oe` high from edge k+1 onward. From then on, after each edge j, `dq_out` carries the `arr_rdata` value that was present at edge j. A consumer sampling at edge k+2 sees the first word (3-1-1-1 timing).
- R3: With `pipe_mode` = 0, a read sampled at edge k makes `dq_oe` high right after edge k, and `dq_out` follows `arr_rdata` combinationally. A consumer sampling at edge k+1 sees the first word (2-1-1-1 timing).
- R4: With `pipe_mode` = 1, a deselect sampled at edge k leaves the bus driven through the cycle after edge k. `dq_oe` falls only after edge k+1.
- R5: With `pipe_mode` = 0, a deselect sampled at edge k turns `dq_oe` off right after edge k.
- R6: An edge with neither `rd_cmd` nor `desel_cmd` keeps the drive state, so a burst continues driving new array words on each beat.
- R7: When `rd_cmd` and `desel_cmd` are both high at an edge, the read wins.
- R8: `out_en` low turns `dq_oe` off and zeroes `dq_out` at once, without a clock edge. Raising it again restores the driven bus without a new command.
- R9: `sleep` high turns `dq_oe` off and zeroes `dq_out` at once. The drive state is kept, so dropping `sleep` brings the bus back without a new command.
- R10: Whenever `dq_oe` is 0, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pipe_mode | input | 1 | 1 = registered output stage, 0 = flow-through; tie high when unused |
| rd_cmd | input | 1 | Read command for this edge |
| desel_cmd | input | 1 | Deselect command for this edge |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous power-down request, active high |
| arr_rdata | input | DATA_W | Read word from the array |
| dq_oe | output | 1 | Bus driver enable |
| dq_out | output | DATA_W | Bus data, zero while not driven |

## Verification
The main stream runs read, burst-beat and deselect commands in both modes. It also issues a read and a deselect in the same cycle, and every beat carries a different array word. In pipelined mode this shows whether the bus lags by the register stage. It also shows whether a deselect keeps the driver on for its extra cycle (dual-cycle deselect) instead of releasing it at once. In flow-through mode the same pattern tells apart the direct path from a stray register on both data and enable. Output-enable and sleep pulses placed between clock edges separate a combinational gate from a clocked one, and show whether the drive state survives the gate.

// File: rtl/sram_read_path_pkg.sv
// Package: shared types and helpers for the SRAM read output path.
// Assumes: one command per rising edge; read has priority over deselect.
package sram_read_path_pkg;

    // Output stage selection, matching the level on the mode input.
    typedef enum logic {
        OSTAGE_FLOW = 1'b0,
        OSTAGE_PIPE = 1'b1
    } ostage_e;

    // Next drive token: read sets it, deselect clears it, otherwise it holds.
    function automatic logic next_drive(input logic cur,
                                        input logic rd,
                                        input logic desel);
        logic nxt;
        nxt = cur;
        if (desel) nxt = 1'b0;
        if (rd)    nxt = 1'b1;
        return nxt;
    endfunction

endpackage

// File: rtl/rdp_token_stage.sv
// Module: rdp_token_stage
// Holds the drive token updated by the incoming command. This is the first
// stage that both reads and deselects pass through.
// Assumes: synchronous active-low reset; commands sampled on the rising edge.
module rdp_token_stage
    import sram_read_path_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic desel,
    output logic token
);

    // Update the token from this edge's command.
    always_ff @(posedge clk) begin
        if (!rst_n) token <= 1'b0;
        else        token <= next_drive(token, rd, desel);
    end

endmodule

// File: rtl/rdp_delay_reg.sv
// Module: rdp_delay_reg
// Plain delay register with reset, used for the second stage of both the
// token and the data word.
// Assumes: synchronous active-low reset to zero.
module rdp_delay_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture the input on every rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/rdp_bus_drive.sv
// Module: rdp_bus_drive
// Selects the token and data for the chosen output stage, then gates the
// driver with the asynchronous output enable and sleep. Data is zeroed
// whenever the driver is off.
// Assumes: the gate inputs may change at any time, not only at clock edges.
module rdp_bus_drive
    import sram_read_path_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  ostage_e           stage,
    input  logic              tok_flow,
    input  logic [DATA_W-1:0] dat_flow,
    input  logic              tok_pipe,
    input  logic [DATA_W-1:0] dat_pipe,
    input  logic              out_en,
    input  logic              sleep,
    output logic              drive_sel,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dat
);

    logic [DATA_W-1:0] dat_sel;

    // Choose the stage feeding the bus.
    always_comb begin
        if (stage == OSTAGE_PIPE) begin
            drive_sel = tok_pipe;
            dat_sel   = dat_pipe;
        end else begin
            drive_sel = tok_flow;
            dat_sel   = dat_flow;
        end
    end

    // Apply the asynchronous gates and force known data when off.
    always_comb begin
        bus_oe  = drive_sel & out_en & ~sleep;
        bus_dat = bus_oe ? dat_sel : '0;
    end

endmodule

// File: rtl/sram_read_path.sv
// Module: sram_read_path (top)
// Read output path of a synchronous SRAM. Reads and deselects share a
// token pipeline so that the enable and the data stay aligned. The
// pipelined stage adds one register to both; flow-through skips it.
// Assumes: the array presents the read word in the cycle after the edge
// that accepted the read; pipe_mode changes only while the bus is idle.
module sram_read_path
    import sram_read_path_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              rd_cmd,
    input  logic              desel_cmd,
    input  logic              out_en,
    input  logic              sleep,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);

    localparam int TOK_W = 1;

    logic              tok_s1;
    logic              tok_s2;
    logic [DATA_W-1:0] dat_s2;
    logic              drive_sel;
    ostage_e           stage;

    // Map the mode pin onto the stage type.
    always_comb stage = ostage_e'(pipe_mode);

    rdp_token_stage u_tok1 (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (rd_cmd),
        .desel (desel_cmd),
        .token (tok_s1)
    );

    rdp_delay_reg #(.WIDTH(TOK_W)) u_tok2 (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tok_s1),
        .q     (tok_s2)
    );

    rdp_delay_reg #(.WIDTH(DATA_W)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (arr_rdata),
        .q     (dat_s2)
    );

    rdp_bus_drive #(.DATA_W(DATA_W)) u_drv (
        .stage     (stage),
        .tok_flow  (tok_s1),
        .dat_flow  (arr_rdata),
        .tok_pipe  (tok_s2),
        .dat_pipe  (dat_s2),
        .out_en    (out_en),
        .sleep     (sleep),
        .drive_sel (drive_sel),
        .bus_oe    (dq_oe),
        .bus_dat   (dq_out)
    );

endmodule

// File: rtl/sram_read_path_chk.sv
// Module: sram_read_path_chk
// Temporal checks on the read output path, bound to the top module.
// Assumes: drive_sel is the stage-selected token before the gates.
module sram_read_path_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_mode,
    input logic              rd_cmd,
    input logic              desel_cmd,
    input logic              out_en,
    input logic              sleep,
    input logic [DATA_W-1:0] arr_rdata,
    input logic              drive_sel,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!dq_oe && dq_out == '0));

    assert_pipe_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && rd_cmd) |-> ##2 (!pipe_mode || drive_sel));

    assert_pipe_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && dq_oe) |-> (dq_out == $past(arr_rdata)));

    assert_flow_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rd_cmd) |=> (pipe_mode || drive_sel));

    assert_flow_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && dq_oe) |-> (dq_out == arr_rdata));

    assert_pipe_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && desel_cmd && !rd_cmd) |-> ##2 (!pipe_mode || !drive_sel));

    assert_flow_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && desel_cmd && !rd_cmd) |=> (pipe_mode || !drive_sel));

    assert_gate_off_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en || sleep) |-> !dq_oe);

    assert_known_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

endmodule

bind sram_read_path sram_read_path_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .rd_cmd    (rd_cmd),
    .desel_cmd (desel_cmd),
    .out_en    (out_en),
    .sleep     (sleep),
    .arr_rdata (arr_rdata),
    .drive_sel (drive_sel),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out)
);

// File: tb/tb_sram_read_path.sv
// Bench: table-driven stream of commands in both modes, then directed
// tests for reset and for gates that move between clock edges.
module tb_sram_read_path;

    localparam int DATA_W = 36;
    localparam int NVEC   = 14;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              pipe_mode;
    logic              rd_cmd;
    logic              desel_cmd;
    logic              out_en;
    logic              sleep;
    logic [DATA_W-1:0] arr_rdata;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sram_read_path #(.DATA_W(DATA_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .rd_cmd    (rd_cmd),
        .desel_cmd (desel_cmd),
        .out_en    (out_en),
        .sleep     (sleep),
        .arr_rdata (arr_rdata),
        .dq_oe     (dq_oe),
        .dq_out    (dq_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    // One vector: inputs held over an edge, expected outputs after it.
    typedef struct packed {
        logic       mode;
        logic       rd;
        logic       ds;
        logic       oe;
        logic       sl;
        logic [7:0] arr;
        logic       exp_oe;
        logic [7:0] exp_dat;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1,1'b1,1'b0,1'b1,1'b0,8'h11,1'b0,8'h00,8'd2},  // R2 read, not yet out
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h22,1'b1,8'h22,8'd2},  // R2 first word
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h33,1'b1,8'h33,8'd6},  // R6 burst beat
        '{1'b1,1'b0,1'b1,1'b1,1'b0,8'h44,1'b1,8'h44,8'd4},  // R4 still driven
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h55,1'b0,8'h00,8'd4},  // R4 released
        '{1'b0,1'b1,1'b0,1'b1,1'b0,8'h66,1'b1,8'h66,8'd3},  // R3 flow read
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h77,1'b1,8'h77,8'd6},  // R6 burst beat
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'h88,1'b0,8'h00,8'd5},  // R5 off at once
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h99,1'b0,8'h00,8'd8},  // R8 gated
        '{1'b0,1'b0,1'b0,1'b1,1'b1,8'hAA,1'b0,8'h00,8'd9},  // R9 sleeping
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'hBB,1'b1,8'hBB,8'd9},  // R9 state kept
        '{1'b1,1'b1,1'b1,1'b1,1'b0,8'hCC,1'b1,8'hCC,8'd7},  // R7 read wins
        '{1'b1,1'b0,1'b1,1'b1,1'b0,8'hDD,1'b1,8'hDD,8'd7},  // R7 token stayed
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'hEE,1'b0,8'h00,8'd10}  // R10 zero when off
    };

    task automatic check(input string tag, input logic exp_oe,
                         input logic [DATA_W-1:0] exp_dat);
        checks++;
        if (dq_oe !== exp_oe || dq_out !== exp_dat) begin
            errors++;
            $display("FAIL %s: oe=%0b dat=%h expected oe=%0b dat=%h",
                     tag, dq_oe, dq_out, exp_oe, exp_dat);
        end
    endtask

    // Advance one edge and settle.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pipe_mode = 1'b1; rd_cmd = 1'b0; desel_cmd = 1'b0;
        out_en = 1'b1; sleep = 1'b0; arr_rdata = '0;
        tick();
        rd_cmd = 1'b1; arr_rdata = 36'h5A5;
        tick();
        tick();
        check("R1 reset", 1'b0, '0);
        rd_cmd = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            pipe_mode = VEC[i].mode;
            rd_cmd    = VEC[i].rd;
            desel_cmd = VEC[i].ds;
            out_en    = VEC[i].oe;
            sleep     = VEC[i].sl;
            arr_rdata = {28'h0, VEC[i].arr};
            tick();
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  VEC[i].exp_oe, {28'h0, VEC[i].exp_dat});
        end

        // R8: output enable acts between edges, pipelined read running.
        pipe_mode = 1'b1; rd_cmd = 1'b1; desel_cmd = 1'b0;
        arr_rdata = 36'h123456789;
        tick();
        rd_cmd = 1'b0;
        tick();
        check("R8 driven before gate", 1'b1, 36'h123456789);
        out_en = 1'b0;
        #0.5;
        check("R8 off without edge", 1'b0, '0);
        out_en = 1'b1;
        #0.5;
        check("R8 back without edge", 1'b1, 36'h123456789);

        // R9: sleep acts between edges and keeps the drive state.
        sleep = 1'b1;
        #0.5;
        check("R9 sleep off without edge", 1'b0, '0);
        tick();
        tick();
        sleep = 1'b0;
        #0.5;
        check("R9 wake keeps state", 1'b1, 36'h123456789);

        // R1: reset in mid-burst clears the bus at the edge.
        rst_n = 1'b0;
        tick();
        check("R1 reset mid burst", 1'b0, '0);
        rst_n = 1'b1;
        tick();
        check("R1 no token after reset", 1'b0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule